// File: doc/BRIEF.md
# Register-Mapped SPI Master

A SPI master controller programmed through a small 32-bit register bus. Software picks the frame width (4, 8 or 16 bits), the clock polarity and phase, the bit order, the direction of the transfer, how the select line behaves between frames and how long it leads the first clock edge. It then loads up to 32 words into the transmit queue, chooses a slave, writes the number of frames minus one and sets the enable bit. The controller shifts the frames out on MOSI, samples MISO into a 32-entry receive queue, and drops its busy flag once the programmed number of frames has gone by.

The serial clock comes from the system clock through an even divider. Each SCLK half-period lasts `divider/2` system cycles, and bit 0 of the divider register is ignored. Clearing the enable bit stops the controller at once: it leaves any frame it is in, empties both queues and clears busy. Shape and divider settings can only be changed while the controller is disabled.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset all selects are high, SCLK and MOSI are low, the control register reads 0, the divider reads 2 and the status register reads 0x0C.
- R2: The control register (offset 0x00) keeps only frame size [1:0], phase bit 6, polarity bit 7, select mode [9:8], lead bit 10, order bit 12 and direction [19:18]. Bit 20 (slave operation) always reads 0. Writes to control and to the divider (0x10) are ignored while enable (0x08, bit 0) is set.
- R3: Frame size 0, 1 and 2 shift 4, 8 and 16 bits. With order bit 0 the MSB goes first, and with 1 the LSB goes first. This holds for both the transmitted word and the assembled received word (receive data at 0x800, transmit data at 0x400).
- R4: When no transfer is running, SCLK rests at the polarity bit. Phase 0 puts the first SCLK edge in the middle of the first bit. Phase 1 puts it at the start of the bit. MISO is sampled in the middle of each bit.
- R5: The first SCLK edge after enable comes 1 + L·H system cycles after the enable write with phase 1, and 1 + (L+1)·H cycles with phase 0. H is the half-period and L is 1 when the lead bit is 0, or 2 when it is 1.
- R6: Between frames the selected line stays low for select mode 0, and goes high for H cycles in mode 1 or 2·H cycles in mode 2. After a high gap, the lead delay applies again.
- R7: Direction 0 transmits and receives, 1 transmits only and leaves the receive queue untouched, and 2 receives only without using the transmit queue and with MOSI held low.
- R8: Enabling runs exactly (frame count + 1) frames, with the count at 0x04. Busy (status bit 0) stays set until the last one ends, and stays set while a frame waits for data.
- R9: Writing 0 to enable aborts any transfer, empties both queues and clears busy by the next cycle.
- R10: Status at 0x24 is {rx full, rx empty, tx empty, tx full, busy} in bits [4:0]. Each queue holds 32 entries. A push into a full transmit queue is dropped.
- R11: Writing a one-hot value to the select register (0x0C) drives that select line low, and writing 0 releases all lines. Any other value is ignored.
- R12: The half-period H is divider/2 system cycles, with a minimum of 1. Bit 0 of the divider is ignored and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; pops the receive queue at 0x800 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
Register writes land on the clock edge of the write strobe, so a read one cycle later already shows the new state. An abort shows in status on the very next read. The first SCLK edge is due exactly 1 + L·H (phase 1) or 1 + (L+1)·H (phase 0) cycles after the enable write. The bench counts falling system-clock edges from the end of that write to the first SCLK change and compares the count with the formula. Gap widths are measured the same way, by counting falling edges with the select high, against H or 2·H. Data results are read only after status shows busy low, since the received word is pushed in the same cycle that busy drops.

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl #(
  parameter int AW    = 12,
  parameter int NSS   = 4,
  parameter int DEPTH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] ss_n
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);
  localparam logic [AW-1:0] A_CTRL = AW'('h000), A_FRM = AW'('h004), A_EN = AW'('h008),
                            A_SS = AW'('h00C), A_BAUD = AW'('h010), A_STAT = AW'('h024),
                            A_TXD = AW'('h400), A_RXD = AW'('h800);
  localparam logic [20:0] CTRL_MASK = 21'h0C17C3;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_BITS, S_GAP, S_HOLD} state_t;

  logic [20:0]    ctrl;
  logic [15:0]    frm, baud, tx_sh, rx_sh;
  logic           en;
  logic [NSS-1:0] ss_reg;
  state_t         state;
  logic [5:0]     k;
  logic [14:0]    hcnt;
  logic [16:0]    rem;
  logic [15:0]    txm [DEPTH];
  logic [15:0]    rxm [DEPTH];
  logic [PW:0]    twp, trp, rwp, rrp;

  wire [1:0] fsz  = ctrl[1:0];
  wire       cpha = ctrl[6];
  wire       cpol = ctrl[7];
  wire [1:0] csm  = ctrl[9:8];
  wire       ssd  = ctrl[10];
  wire       lsb  = ctrl[12];
  wire [1:0] tmod = ctrl[19:18];

  wire [4:0]  nb   = (fsz == 2'd0) ? 5'd4 : (fsz == 2'd1) ? 5'd8 : 5'd16;
  wire [14:0] half = (baud[15:1] == 15'd0) ? 15'd1 : baud[15:1];
  wire        tick = (hcnt == half - 15'd1);
  wire        last = (k == {nb, 1'b0} - 6'd1);

  wire tx_empty = (twp == trp);
  wire tx_full  = ((twp - trp) == FULL);
  wire rx_empty = (rwp == rrp);
  wire rx_full  = ((rwp - rrp) == FULL);
  wire need_tx  = (tmod != 2'd2);
  wire need_rx  = (tmod != 2'd1);
  wire ready    = (!need_tx || !tx_empty) && (!need_rx || !rx_full);
  wire busy     = (state != S_IDLE) || (rem != '0);

  wire flush     = bus_we && bus_addr == A_EN && !bus_wdata[0];
  wire frame_end = (state == S_BITS) && tick && last;
  wire load      = !flush && ready && ((state == S_IDLE && rem != '0) || state == S_HOLD ||
                                       (frame_end && csm == 2'd0 && rem > 17'd1));
  wire push_tx   = bus_we && bus_addr == A_TXD && !tx_full;
  wire pop_tx    = load && need_tx;
  wire push_rx   = frame_end && need_rx;
  wire pop_rx    = bus_re && bus_addr == A_RXD && !rx_empty;

  wire [15:0] rx_word = lsb ? (rx_sh >> (5'd16 - nb)) : rx_sh;
  wire        tx_bit  = lsb ? tx_sh[0] : tx_sh[4'(nb - 5'd1)];
  wire [NSS-1:0] ss_w = bus_wdata[NSS-1:0];

  assign sclk = (state == S_BITS) ? (cpol ^ (cpha ? ~k[0] : k[0])) : cpol;
  assign mosi = (state == S_BITS) ? tx_bit : 1'b0;
  assign ss_n = ~(ss_reg & {NSS{state != S_GAP}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; frm <= '0; en <= 1'b0; ss_reg <= '0; baud <= 16'd2;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL: if (!en) ctrl <= bus_wdata[20:0] & CTRL_MASK;
        A_FRM:  frm <= bus_wdata[15:0];
        A_EN:   en <= bus_wdata[0];
        A_SS:   if ((ss_w & (ss_w - 1'b1)) == '0) ss_reg <= ss_w;
        A_BAUD: if (!en) baud <= {bus_wdata[15:1], 1'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; k <= '0; hcnt <= '0; rem <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (flush) begin
      state <= S_IDLE; k <= '0; hcnt <= '0; rem <= '0;
    end else begin
      if (bus_we && bus_addr == A_EN && bus_wdata[0] && !en) rem <= {1'b0, frm} + 17'd1;
      if (load) begin
        tx_sh <= need_tx ? txm[trp[PW-1:0]] : '0;
        rx_sh <= '0;
      end
      case (state)
        S_IDLE: if (load) begin state <= S_LEAD; k <= '0; hcnt <= '0; end
        S_LEAD:
          if (tick) begin
            hcnt <= '0;
            if (k[0] == ssd) begin state <= S_BITS; k <= '0; end
            else k <= k + 6'd1;
          end else hcnt <= hcnt + 15'd1;
        S_BITS:
          if (tick) begin
            hcnt <= '0;
            if (!k[0]) rx_sh <= lsb ? {miso, rx_sh[15:1]} : {rx_sh[14:0], miso};
            else if (!last) tx_sh <= lsb ? (tx_sh >> 1) : (tx_sh << 1);
            if (last) begin
              rem <= rem - 17'd1;
              k   <= '0;
              if (rem == 17'd1)        state <= S_IDLE;
              else if (csm == 2'd0)    state <= load ? S_BITS : S_HOLD;
              else                     state <= S_GAP;
            end else k <= k + 6'd1;
          end else hcnt <= hcnt + 15'd1;
        S_GAP:
          if (tick) begin
            hcnt <= '0;
            if (k[0] == (csm != 2'd1)) begin state <= S_IDLE; k <= '0; end
            else k <= k + 6'd1;
          end else hcnt <= hcnt + 15'd1;
        S_HOLD: if (load) begin state <= S_BITS; k <= '0; hcnt <= '0; end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
    end else if (flush) begin
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
    end else begin
      if (push_tx) twp <= twp + 1'b1;
      if (pop_tx)  trp <= trp + 1'b1;
      if (push_rx) rwp <= rwp + 1'b1;
      if (pop_rx)  rrp <= rrp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_tx) txm[twp[PW-1:0]] <= bus_wdata[15:0];
    if (push_rx) rxm[rwp[PW-1:0]] <= rx_word;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[20:0]    = ctrl;
      A_FRM:  bus_rdata[15:0]    = frm;
      A_EN:   bus_rdata[0]       = en;
      A_SS:   bus_rdata[NSS-1:0] = ss_reg;
      A_BAUD: bus_rdata[15:0]    = baud;
      A_STAT: bus_rdata[4:0]     = {rx_full, rx_empty, tx_empty, tx_full, busy};
      A_RXD:  bus_rdata[15:0]    = rx_empty ? 16'd0 : rxm[rrp[PW-1:0]];
      default: ;
    endcase
  end

  // R11
  ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ss_n));
  // R10
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n) (twp - trp) <= FULL);
  // R10
  rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n) (rwp - rrp) <= FULL);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN && !bus_wdata[0]) |=> (state == S_IDLE && rem == '0 && twp == trp && rwp == rrp));
  // R8
  count_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_end |-> rem != '0);
  // R4
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk == ctrl[7]);
endmodule

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0] addr = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso;
  logic [3:0] ss_n;

  spi_host_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_re(re),
                     .bus_wdata(wdata), .bus_rdata(rdata), .sclk(sclk), .mosi(mosi),
                     .miso(miso), .ss_n(ss_n));

  localparam logic [11:0] A_CTRL = 12'h000, A_FRM = 12'h004, A_EN = 12'h008, A_SS = 12'h00C,
                          A_BAUD = 12'h010, A_STAT = 12'h024, A_TXD = 12'h400, A_RXD = 12'h800;

  // {size[36:35], phase, polarity, lsb-first, tx[31:16], slave word[15:0]}
  localparam logic [36:0] VEC [6] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C},
    {2'd1, 1'b1, 1'b0, 1'b1, 16'h0081, 16'h0096},
    {2'd0, 1'b0, 1'b1, 1'b0, 16'h0009, 16'h0006},
    {2'd2, 1'b1, 1'b1, 1'b0, 16'hBEEF, 16'h1234},
    {2'd2, 1'b0, 1'b1, 1'b1, 16'hC3A5, 16'h0F0E},
    {2'd0, 1'b1, 1'b0, 1'b1, 16'h000E, 16'h0001}
  };

  int errors = 0, checks = 0;
  logic b_cpol = 1'b0, b_cpha = 1'b0;
  int b_nb = 8, idx = 0, hi_cnt = 0;
  logic [15:0] b_sw = '0, cap = '0;
  logic prev_sclk = 1'b0, mon = 1'b0;

  assign miso = b_sw[4'(b_nb - 1 - idx)];

  always @(negedge clk) begin
    if (ss_n[0]) begin
      idx <= 0; cap <= '0;
    end else if (sclk != prev_sclk) begin
      if ((sclk != b_cpol) != b_cpha) cap <= {cap[14:0], mosi};
      if (sclk == b_cpol) idx <= (idx == b_nb - 1) ? 0 : idx + 1;
    end
    prev_sclk <= sclk;
    if (!mon) hi_cnt <= 0;
    else if (ss_n[0]) hi_cnt <= hi_cnt + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  task automatic cfg(input int fs, input logic ph, input logic po, input logic lf,
                     input int cs, input logic ld, input int dir);
    b_cpol = po; b_cpha = ph;
    b_nb = (fs == 0) ? 4 : (fs == 1) ? 8 : 16;
    wr(A_CTRL, fs | (32'(ph) << 6) | (32'(po) << 7) | (cs << 8) | (32'(ld) << 10) |
               (32'(lf) << 12) | (dir << 18));
  endtask

  function automatic logic [15:0] rev(input logic [15:0] v, input int n);
    logic [15:0] o = '0;
    for (int i = 0; i < n; i++) o[n-1-i] = v[i];
    return o;
  endfunction

  task automatic lead_run(input logic ph, input logic ld, input int bd, input int exp, input string r);
    int n = 0;
    cfg(1, ph, 1'b0, 1'b0, 0, ld, 0);
    wr(A_BAUD, bd); wr(A_FRM, 0); wr(A_SS, 1); wr(A_TXD, 0);
    wr(A_EN, 1);
    while (sclk == 1'b0 && n < 1000) begin @(negedge clk); n++; end
    chk(r, n, exp);
    wait_idle(); wr(A_EN, 0); wr(A_SS, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 ss_n", ss_n, 4'hF);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0C);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_BAUD, d); chk("R1 baud", d, 2);

    // R3 R4 table of frame shapes
    for (int v = 0; v < 6; v++) begin
      logic [36:0] e = VEC[v];
      int n = (e[36:35] == 0) ? 4 : (e[36:35] == 1) ? 8 : 16;
      logic [15:0] m = 16'((32'd1 << n) - 1);
      b_sw = e[15:0];
      cfg(int'(e[36:35]), e[34], e[33], e[32], 0, 1'b1, 0);
      wr(A_BAUD, 4); wr(A_FRM, 0); wr(A_SS, 1); wr(A_TXD, {16'd0, e[31:16]});
      wr(A_EN, 1);
      wait_idle();
      rd(A_RXD, d);
      chk("R3 rx word", d, e[32] ? rev(e[15:0], n) : (e[15:0] & m));
      chk("R4 mosi bits", cap, e[32] ? rev(e[31:16], n) : (e[31:16] & m));
      chk("R4 idle level", sclk, e[33]);
      wr(A_EN, 0); wr(A_SS, 0);
    end

    // R5 lead delay, R12 divider
    lead_run(1'b1, 1'b0, 8, 5, "R5 lead half");
    lead_run(1'b1, 1'b1, 8, 9, "R5 lead full");
    lead_run(1'b0, 1'b1, 8, 13, "R5 lead phase0");
    lead_run(1'b1, 1'b0, 9, 5, "R12 odd divider");
    lead_run(1'b1, 1'b0, 4, 3, "R12 small divider");
    wr(A_BAUD, 9); rd(A_BAUD, d); chk("R12 baud bit0", d, 8);

    // R6 select gaps, R8 two frames
    for (int cs = 0; cs < 3; cs++) begin
      b_sw = 16'h005A;
      cfg(1, 1'b0, 1'b0, 1'b0, cs, 1'b1, 0);
      wr(A_BAUD, 8); wr(A_FRM, 1); wr(A_SS, 1);
      wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
      mon = 1'b1;
      wr(A_EN, 1);
      wait_idle();
      chk("R6 gap width", hi_cnt, cs * 4);
      mon = 1'b0;
      rd(A_RXD, d); chk("R8 frame one", d, 32'h5A);
      rd(A_RXD, d); chk("R8 frame two", d, 32'h5A);
      rd(A_STAT, d); chk("R8 rx drained", d, 32'h0C);
      wr(A_EN, 0); wr(A_SS, 0);
    end

    // R7 transmit only, R8 count honoured with spare word
    cfg(1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1);
    wr(A_BAUD, 4); wr(A_FRM, 0); wr(A_SS, 1);
    wr(A_TXD, 32'h3C); wr(A_TXD, 32'h77);
    wr(A_EN, 1); wait_idle();
    chk("R7 tx only mosi", cap, 16'h3C);
    rd(A_STAT, d); chk("R7 R8 status", d, 32'h08);
    wr(A_EN, 0);
    rd(A_STAT, d); chk("R9 flush", d, 32'h0C);
    wr(A_SS, 0);

    // R7 receive only
    b_sw = 16'h00C5;
    cfg(1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 2);
    wr(A_FRM, 0); wr(A_SS, 1);
    wr(A_EN, 1); wait_idle();
    rd(A_RXD, d); chk("R7 rx only data", d, 32'hC5);
    chk("R7 rx only mosi low", cap, 0);
    wr(A_EN, 0); wr(A_SS, 0);

    // R9 abort mid transfer
    cfg(1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    wr(A_BAUD, 32'hFFFE); wr(A_FRM, 3); wr(A_SS, 1);
    wr(A_TXD, 1); wr(A_TXD, 2);
    wr(A_EN, 1);
    repeat (20) @(negedge clk);
    rd(A_STAT, d); chk("R9 busy before abort", d[0], 1);
    wr(A_EN, 0);
    rd(A_STAT, d); chk("R9 after abort", d, 32'h0C);
    chk("R9 sclk idle", sclk, 0);
    wr(A_SS, 0);

    // R2 field mask and write lock
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 field mask", d, 32'h000C17C3);
    cfg(1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);
    wr(A_BAUD, 8); wr(A_FRM, 0);
    wr(A_EN, 1);
    wr(A_CTRL, 2); rd(A_CTRL, d); chk("R2 ctrl locked", d, 1);
    wr(A_BAUD, 32'h40); rd(A_BAUD, d); chk("R2 baud locked", d, 8);
    rd(A_STAT, d); chk("R8 stalled busy", d, 32'h0D);
    wr(A_EN, 0);

    // R10 queue limits
    b_sw = 16'h000A;
    cfg(0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 0);
    wr(A_BAUD, 2); wr(A_FRM, 31); wr(A_SS, 1);
    for (int i = 0; i < 32; i++) wr(A_TXD, i);
    rd(A_STAT, d); chk("R10 tx full", d, 32'h0A);
    wr(A_TXD, 32'hF);
    wr(A_EN, 1); wait_idle();
    rd(A_STAT, d); chk("R10 dropped push, rx full", d, 32'h14);
    rd(A_RXD, d); chk("R10 rx head", d, 32'hA);
    rd(A_STAT, d); chk("R10 rx not full", d, 32'h04);
    wr(A_EN, 0); wr(A_SS, 0);

    // R11 select register
    wr(A_SS, 4); chk("R11 one-hot", ss_n, 4'b1011);
    wr(A_SS, 3); chk("R11 ignored", ss_n, 4'b1011);
    rd(A_SS, d); chk("R11 readback", d, 4);
    wr(A_SS, 0); chk("R11 release", ss_n, 4'hF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule